// File: doc/BRIEF.md
# Four-Role Test Register

This block is an N-bit register that can take one of four roles, chosen by two control bits: an ordinary bank of flip-flops that captures parallel data, a serial scan chain, a self-running pseudo-random pattern source, or a signature compactor that folds parallel data into its feedback state. All four roles share the same N flops, so the same hardware that holds functional state can also drive or observe a block of logic during self-test.

The feedback network implements division by the polynomial 1 + x + x^N in modular form: the last stage wraps into stage 0, and it is also XORed into stage 1. The register has no reset input. It is cleared, or loaded with a seed, by shifting values in through the serial input. The serial output is always the last stage. A signature built in compactor mode can therefore be shifted out in scan mode.

A typical use places two of these registers around a piece of combinational logic. In one test session the first register generates patterns and the second compacts the logic's responses. In the next session the two swap roles.

Top module: `modal_test_reg`

## Requirements
- R1: The mode is {b1,b2}, with b1 as the high bit. 2'b11 selects functional capture, 2'b10 selects signature compaction, 2'b01 selects pattern generation and 2'b00 selects scan. Each mode acts on the rising clock edge.
- R2: In scan mode each clock loads q[0] from si and q[i] from q[i-1] for every i from 1 to N-1.
- R3: In functional mode each clock loads q from d.
- R4: In generator mode each clock sets q[0] to the old q[N-1], q[1] to the old q[0] XOR q[N-1], and q[i] to the old q[i-1] for i of 2 or more. The input d has no effect on the result.
- R5: In compactor mode each clock computes the same next state as in R4, XORed bit by bit with d.
- R6: so always equals q[N-1]. N scan clocks with si = 0 leave q all zero from any starting state.
- R7: In generator mode an all-zero register stays all zero, whatever d is.
- R8: After compaction, N scan clocks present the signature on so, starting with bit N-1 and ending with bit 0. so is sampled before each shift.
- R9: Two registers around a combinational block can swap roles between sessions. The compactor's final state equals the division result that R5 predicts for the responses to the generator's sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| b1 | input | 1 | Mode control, high bit |
| b2 | input | 1 | Mode control, low bit |
| d | input | N | Parallel data from the preceding logic |
| si | input | 1 | Serial scan input into stage 0 |
| q | output | N | Parallel register state |
| so | output | 1 | Serial output, the last stage |

## Verification
Each mode is first driven with directed patterns: an all-zero clear by scan, a zero-state run in generator mode, and a nonzero seed followed by generation while d is randomized. Randomized d in generator mode shows that d is ignored. The same randomized d in compactor mode must change the result, and this separates the two feedback roles. A long stretch of random mode changes with random d and si then catches wrong decoding and stale state at mode boundaries. Finally, two instances surround a small combinational function in both role assignments, and each signature is read back serially through so. This exposes wrong tap positions, a wrong shift direction and a wrong serial-out stage.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  typedef enum logic [1:0] {
    MODE_SCAN = 2'b00,
    MODE_GEN  = 2'b01,
    MODE_SIG  = 2'b10,
    MODE_FUNC = 2'b11
  } mode_e;

  typedef struct packed {
    logic loadPar;   // capture parallel input
    logic shiftScan; // serial shift
    logic runFb;     // polynomial feedback step
    logic mixIn;     // fold parallel input into feedback
  } strobe_t;
endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
(
  input  logic    modeHi,
  input  logic    modeLo,
  output strobe_t stb
);
  mode_e modeSel;

  assign modeSel = mode_e'({modeHi, modeLo});

  // R1: role decode
  always_comb begin
    stb = '0;
    case (modeSel)
      MODE_FUNC: stb.loadPar = 1'b1;
      MODE_SCAN: stb.shiftScan = 1'b1;
      MODE_GEN:  stb.runFb = 1'b1;
      MODE_SIG: begin
        stb.runFb = 1'b1;
        stb.mixIn = 1'b1;
      end
      default: stb = '0;
    endcase
  end
endmodule

// File: rtl/mtr_path.sv
module mtr_path
  import mtr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  strobe_t      stb,
  input  logic [N-1:0] parIn,
  input  logic         serIn,
  output logic [N-1:0] state
);
  localparam int LAST = N - 1;

  logic [N-1:0] stepVal;
  logic [N-1:0] mixVal;
  logic [N-1:0] nextVal;

  // Modular divider by 1 + x + x^N: taps at stage 0 and stage 1
  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_wrap
        assign stepVal[i] = state[LAST];
      end else if (i == 1) begin : g_tap
        assign stepVal[i] = state[0] ^ state[LAST];
      end else begin : g_pass
        assign stepVal[i] = state[i-1];
      end
    end
  endgenerate

  assign mixVal = stb.mixIn ? parIn : '0;

  always_comb begin
    if (stb.loadPar)        nextVal = parIn;
    else if (stb.shiftScan) nextVal = {state[LAST-1:0], serIn};
    else if (stb.runFb)     nextVal = stepVal ^ mixVal;
    else                    nextVal = state;
  end

  always_ff @(posedge clk) state <= nextVal;

  // History guard for assertions: no reset exists, so wait one edge
  logic histOk = 1'b0;
  always_ff @(posedge clk) histOk <= 1'b1;

  a_r2_scan_shift: assert property (@(posedge clk) disable iff (!histOk)
    stb.shiftScan |=> (state[0] == $past(serIn)) && (state[LAST:1] == $past(state[LAST-1:0])));

  a_r3_func_load: assert property (@(posedge clk) disable iff (!histOk)
    stb.loadPar |=> state == $past(parIn));

  a_r4_gen_rotate: assert property (@(posedge clk) disable iff (!histOk)
    (stb.runFb && !stb.mixIn) |=> (state[0] == $past(state[LAST]))
      && (state[1] == ($past(state[0]) ^ $past(state[LAST]))));

  a_r5_sig_fold: assert property (@(posedge clk) disable iff (!histOk)
    (stb.runFb && stb.mixIn) |=> state[0] == ($past(state[LAST]) ^ $past(parIn[0])));

  a_r7_zero_lock: assert property (@(posedge clk) disable iff (!histOk)
    (stb.runFb && !stb.mixIn && state == '0) |=> state == '0);
endmodule

// File: rtl/modal_test_reg.sv
module modal_test_reg
  import mtr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         b1,
  input  logic         b2,
  input  logic [N-1:0] d,
  input  logic         si,
  output logic [N-1:0] q,
  output logic         so
);
  strobe_t stb;

  mtr_ctrl u_ctrl (
    .modeHi (b1),
    .modeLo (b2),
    .stb    (stb)
  );

  mtr_path #(.N(N)) u_path (
    .clk   (clk),
    .stb   (stb),
    .parIn (d),
    .serIn (si),
    .state (q)
  );

  // R6: serial output is the last stage in every mode
  assign so = q[N-1];
endmodule

// File: tb/modal_test_reg_test.sv
module modal_test_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]   modeA = 2'b00, modeB = 2'b00;
  logic [W-1:0] dAr = '0, dBr = '0;
  logic         siA = 1'b0, siB = 1'b0;
  logic         linkA = 1'b0, linkB = 1'b0;
  logic [W-1:0] qA, qB, dA, dB;
  logic         soA, soB;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] cutFn(input logic [W-1:0] x);
    return x ^ {x[W-2:0], x[W-1]} ^ 8'hA5;
  endfunction

  assign dA = linkA ? cutFn(qB) : dAr;
  assign dB = linkB ? cutFn(qA) : dBr;

  modal_test_reg #(.N(W)) uut (
    .clk(clk), .b1(modeA[1]), .b2(modeA[0]), .d(dA), .si(siA), .q(qA), .so(soA));
  modal_test_reg #(.N(W)) uutB (
    .clk(clk), .b1(modeB[1]), .b2(modeB[0]), .d(dB), .si(siB), .q(qB), .so(soB));

  logic [W-1:0] mdlA = '0, mdlB = '0;

  function automatic logic [W-1:0] divStep(input logic [W-1:0] x);
    logic [W-1:0] r;
    r = {x[W-2:0], x[W-1]};
    r[1] = r[1] ^ x[W-1];
    return r;
  endfunction

  function automatic logic [W-1:0] nextFn(input logic [1:0] m, input logic [W-1:0] x,
                                          input logic [W-1:0] din, input logic s);
    case (m)
      2'b11:   return din;
      2'b00:   return {x[W-2:0], s};
      2'b01:   return divStep(x);
      default: return divStep(x) ^ din;
    endcase
  endfunction

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b11:   return "R1/R3";
      2'b00:   return "R1/R2";
      2'b01:   return "R1/R4";
      default: return "R1/R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, advance one edge, sample at next negedge
  task automatic step(input logic [1:0] mA, input logic [W-1:0] vA, input logic sA,
                      input logic [1:0] mB, input logic [W-1:0] vB, input logic sB,
                      input string tagA, input string tagB);
    logic [W-1:0] expA, expB;
    modeA = mA; dAr = vA; siA = sA;
    modeB = mB; dBr = vB; siB = sB;
    expA = nextFn(mA, mdlA, linkA ? cutFn(mdlB) : vA, sA);
    expB = nextFn(mB, mdlB, linkB ? cutFn(mdlA) : vB, sB);
    @(posedge clk);
    @(negedge clk);
    mdlA = expA;
    mdlB = expB;
    check(qA === expA, tagA, qA, expA);
    check(qB === expB, tagB, qB, expB);
    check(soA === expA[W-1], "R6 so", {7'd0, soA}, {7'd0, expA[W-1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] seed, sig;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);

    // R6: clear by scanning zeros
    for (int i = 0; i < W; i++) step(2'b00, 8'hFF, 1'b0, 2'b00, 8'h00, 1'b0, "R2", "R2");
    check(qA === '0, "R6 clear", qA, '0);
    check(qB === '0, "R6 clear", qB, '0);

    // R7: all-zero generator stays zero
    for (int i = 0; i < 6; i++) begin
      step(2'b01, W'($urandom), 1'b0, 2'b01, W'($urandom), 1'b0, "R4", "R4");
      check(qA === '0, "R7 lockup", qA, '0);
    end

    // R2: scan in a nonzero seed
    seed = 8'h96;
    for (int i = W - 1; i >= 0; i--) step(2'b00, 8'h00, seed[i], 2'b00, 8'h00, 1'b1, "R2", "R2");
    check(qA === seed, "R2 seed", qA, seed);

    // R4: generator with random d that must be ignored
    for (int i = 0; i < 20; i++) step(2'b01, W'($urandom), 1'b0, 2'b01, W'($urandom), 1'b0, "R4", "R4");
    // R3: functional capture
    for (int i = 0; i < 10; i++) step(2'b11, W'($urandom), 1'b0, 2'b11, W'($urandom), 1'b0, "R3", "R3");
    step(2'b11, 8'h00, 1'b0, 2'b11, 8'hFF, 1'b0, "R3", "R3");
    // R5: compaction
    for (int i = 0; i < 10; i++) step(2'b10, W'($urandom), 1'b0, 2'b10, W'($urandom), 1'b0, "R5", "R5");

    // Random mode mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] ma, mb;
      ma = 2'($urandom);
      mb = 2'($urandom);
      step(ma, W'($urandom), 1'($urandom), mb, W'($urandom), 1'($urandom), reqOf(ma), reqOf(mb));
    end

    // R9 session 1: A generates, B compacts
    for (int i = 0; i < W; i++) step(2'b00, 8'h00, 1'b1, 2'b00, 8'h00, 1'b0, "R2", "R2");
    linkB = 1'b1;
    for (int i = 0; i < 40; i++) step(2'b01, 8'h00, 1'b0, 2'b10, 8'h00, 1'b0, "R9 gen A", "R9 sig B");
    linkB = 1'b0;
    check(qB === mdlB, "R9 signature B", qB, mdlB);
    sig = mdlB;
    // R8: shift the signature out
    for (int k = 0; k < W; k++) begin
      check(soB === sig[W-1-k], "R8 unload B", {7'd0, soB}, {7'd0, sig[W-1-k]});
      step(2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b0, "R2", "R2");
    end

    // R9 session 2: roles swapped
    seed = 8'h3C;
    for (int i = W - 1; i >= 0; i--) step(2'b00, 8'h00, 1'b0, 2'b00, 8'h00, seed[i], "R2", "R2");
    linkA = 1'b1;
    for (int i = 0; i < 40; i++) step(2'b10, 8'h00, 1'b0, 2'b01, 8'h00, 1'b0, "R9 sig A", "R9 gen B");
    linkA = 1'b0;
    check(qA === mdlA, "R9 signature A", qA, mdlA);
    sig = mdlA;
    for (int k = 0; k < W; k++) begin
      check(soA === sig[W-1-k], "R8 unload A", {7'd0, soA}, {7'd0, sig[W-1-k]});
      step(2'b00, 8'h00, 1'b0, 2'b00, 8'h00, 1'b0, "R2", "R2");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule